// File: doc/BRIEF.md
# Root-Port Bring-Up Reset Sequencer

This block brings a PCIe root-port controller and its PHY out of reset after a single start command. It powers the PHY up by writing a control word, holds every reset line low, and checks that the reference clock is confirmed good. If the clock is not good, it stops with an error. If the clock is good, it releases the bus-interface (APB) and PHY resets together, waits one hold interval, releases the reset of one chosen controller, and waits another hold interval. It then pulses the downstream reset pin (PERST#) low for a longer interval and, once the pin is released, raises the link-training enable.

All waits come from one down-counter. The counter is loaded from microsecond values scaled by a cycles-per-microsecond parameter, so the defaults give 1 ms hold gaps and a 5 ms PERST# pulse at 100 MHz. A power-down command returns the PHY word to its off value and pulls every reset low, whatever the sequencer is doing. A mode input skips the PERST# pulse when the pin serves another function. The controller index and this mode input are captured when a start is accepted.

Top module: `rbs_bringup_seq`

## Requirements
- R1: After reset, phy_pwr_o is 0x1D, all reset outputs (apb_rst_n_o, phy_rst_n_o, ctrl_rst_n_o) are 0, perst_n_o is 1, and train_en_o, busy_o, ready_o and err_o are 0.
- R2: A start accepted at a clock edge sets phy_pwr_o to 0x1C and busy_o to 1 from that edge, with every reset output still 0.
- R3: refclk_ok_i is sampled at the first edge after the accepted start. If it is 0, err_o rises at that edge and busy_o falls, all reset outputs stay 0, and phy_pwr_o stays 0x1C.
- R4: If refclk_ok_i is 1 at that edge, apb_rst_n_o and phy_rst_n_o both rise at that same edge. No controller reset is released before them.
- R5: Exactly H = HOLD_US*CYC_PER_US cycles after the APB/PHY release, one controller reset rises. If the captured index equals 1, the bit is ctrl_rst_n_o[0]. For any other index, the bit is ctrl_rst_n_o[1]. The other bit stays 0.
- R6: H cycles after the controller release, perst_n_o goes low for exactly P = PULSE_US*CYC_PER_US cycles. At the edge where it returns high, train_en_o rises and ready_o is high for that one cycle only.
- R7: When the captured perst_skip_i is 1, perst_n_o never goes low, and train_en_o and the one-cycle ready_o pulse come H cycles after the controller release.
- R8: busy_o is 1 from the accepted start until the edge where train_en_o rises or err_o rises. busy_o and train_en_o are never 1 together.
- R9: pwr_down_i sets, at the next edge and from any state, phy_pwr_o to 0x1D, all reset outputs to 0, perst_n_o to 1, and train_en_o, busy_o and err_o to 0. It takes priority over a start presented in the same cycle.
- R10: start_i is accepted only when the sequencer is idle or in the error state. A start while a sequence is running or after training is enabled changes no output.
- R11: ctrl_idx_i and perst_skip_i are captured when a start is accepted. Changing them later in the sequence has no effect on which controller bit is released or on the PERST# pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start the bring-up sequence |
| pwr_down_i | input | 1 | Power down the PHY and re-assert all resets |
| refclk_ok_i | input | 1 | Reference clock confirmed at its nominal rate |
| ctrl_idx_i | input | IDX_W | Controller index; 1 selects bit 0, any other value selects bit 1 |
| perst_skip_i | input | 1 | Suppress the PERST# pulse (pin shared with another function) |
| phy_pwr_o | output | 8 | PHY power-control word (0x1C on, 0x1D off) |
| apb_rst_n_o | output | 1 | Active-low APB reset |
| phy_rst_n_o | output | 1 | Active-low PHY reset |
| ctrl_rst_n_o | output | 2 | Active-low controller resets |
| perst_n_o | output | 1 | Downstream PERST# |
| train_en_o | output | 1 | Link-training enable |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | One-cycle pulse when training is enabled |
| err_o | output | 1 | Reference clock check failed |

## Verification
The hardest situations to reach from the ports are inputs that change while the sequencer is busy in the middle of a wait. These are a second start, a new controller index or skip mode while a hold gap is counting down, and a power-down arriving between the controller release and the PERST# pulse. The stimulus sets these up with short bench-chosen delay parameters and times the disturbances by cycle count from the accepted start. A timed reference model, keyed on the number of edges since that start, predicts every output on every cycle. It also covers the recovery path: a failed clock check followed by a restart from the error state.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_CHECK,
    SQ_GAP_CORE,
    SQ_GAP_CTRL,
    SQ_PERST,
    SQ_LINK,
    SQ_FAULT
  } seq_state_e;

  localparam logic [7:0] PHY_WORD_ON  = 8'h1C;
  localparam logic [7:0] PHY_WORD_OFF = 8'h1D;
  localparam int unsigned N_CTRL = 2;

  // delay in cycles, never less than one
  function automatic int unsigned us_to_cyc(input int unsigned us, input int unsigned per_us);
    int unsigned c;
    c = us * per_us;
    return (c == 0) ? 1 : c;
  endfunction

  // controller index 1 maps to slot 0, any other index to slot 1
  function automatic logic pick_slot(input logic [31:0] idx);
    return (idx == 32'd1) ? 1'b0 : 1'b1;
  endfunction

  function automatic logic [N_CTRL-1:0] slot_mask(input logic slot);
    logic [N_CTRL-1:0] m;
    m = '0;
    m[slot] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/rbs_delay_timer.sv
module rbs_delay_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/rbs_reset_bank.sv
module rbs_reset_bank
  import rbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_all_i,
  input  logic              rel_core_i,
  input  logic              rel_ctrl_i,
  input  logic              slot_i,
  output logic              apb_rst_n_o,
  output logic              phy_rst_n_o,
  output logic [N_CTRL-1:0] ctrl_rst_n_o
);

  logic [N_CTRL-1:0] sel_mask;
  assign sel_mask = slot_mask(slot_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      apb_rst_n_o <= 1'b0;
      phy_rst_n_o <= 1'b0;
    end else if (hold_all_i) begin
      apb_rst_n_o <= 1'b0;
      phy_rst_n_o <= 1'b0;
    end else if (rel_core_i) begin
      apb_rst_n_o <= 1'b1;
      phy_rst_n_o <= 1'b1;
    end
  end

  for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_rst_n_o[g] <= 1'b0;
      end else if (hold_all_i) begin
        ctrl_rst_n_o[g] <= 1'b0;
      end else if (rel_ctrl_i && sel_mask[g]) begin
        ctrl_rst_n_o[g] <= 1'b1;
      end
    end
  end

  // a controller never leaves reset ahead of the APB and PHY resets
  assert_core_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ctrl_rst_n_o) |-> (apb_rst_n_o && phy_rst_n_o));

  assert_single_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctrl_rst_n_o));

  assert_hold_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_all_i |=> (!apb_rst_n_o && !phy_rst_n_o && ctrl_rst_n_o == '0));

endmodule

// File: rtl/rbs_seq_fsm.sv
module rbs_seq_fsm
  import rbs_pkg::*;
#(
  parameter int unsigned CW        = 8,
  parameter int unsigned IDX_W     = 2,
  parameter int unsigned HOLD_CYC  = 4,
  parameter int unsigned PULSE_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             pwr_down_i,
  input  logic             refclk_ok_i,
  input  logic [IDX_W-1:0] ctrl_idx_i,
  input  logic             perst_skip_i,
  input  logic             expired_i,
  output logic             load_o,
  output logic [CW-1:0]    load_val_o,
  output logic             hold_all_o,
  output logic             rel_core_o,
  output logic             rel_ctrl_o,
  output logic             slot_o,
  output logic             pwr_on_o,
  output logic             perst_n_o,
  output logic             train_en_o,
  output logic             busy_o,
  output logic             ready_o,
  output logic             err_o
);

  localparam logic [CW-1:0] HOLD_LD  = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYC - 1);

  seq_state_e st_q, st_d;
  logic       skip_q;
  logic       accept_start;
  logic       clk_fail;
  logic       is_busy_d;

  always_comb begin
    st_d         = st_q;
    load_o       = 1'b0;
    load_val_o   = '0;
    hold_all_o   = 1'b0;
    rel_core_o   = 1'b0;
    rel_ctrl_o   = 1'b0;
    accept_start = 1'b0;
    clk_fail     = 1'b0;
    if (pwr_down_i) begin
      hold_all_o = 1'b1;
      st_d       = SQ_IDLE;
    end else begin
      case (st_q)
        SQ_IDLE, SQ_FAULT: begin
          if (start_i) begin
            accept_start = 1'b1;
            hold_all_o   = 1'b1;
            st_d         = SQ_CHECK;
          end
        end
        SQ_CHECK: begin
          if (refclk_ok_i) begin
            rel_core_o = 1'b1;
            load_o     = 1'b1;
            load_val_o = HOLD_LD;
            st_d       = SQ_GAP_CORE;
          end else begin
            clk_fail = 1'b1;
            st_d     = SQ_FAULT;
          end
        end
        SQ_GAP_CORE: begin
          if (expired_i) begin
            rel_ctrl_o = 1'b1;
            load_o     = 1'b1;
            load_val_o = HOLD_LD;
            st_d       = SQ_GAP_CTRL;
          end
        end
        SQ_GAP_CTRL: begin
          if (expired_i) begin
            if (skip_q) begin
              st_d = SQ_LINK;
            end else begin
              load_o     = 1'b1;
              load_val_o = PULSE_LD;
              st_d       = SQ_PERST;
            end
          end
        end
        SQ_PERST: begin
          if (expired_i) st_d = SQ_LINK;
        end
        SQ_LINK: st_d = SQ_LINK;
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  assign is_busy_d = (st_d == SQ_CHECK) || (st_d == SQ_GAP_CORE) ||
                     (st_d == SQ_GAP_CTRL) || (st_d == SQ_PERST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SQ_IDLE;
      skip_q     <= 1'b0;
      slot_o     <= 1'b1;
      pwr_on_o   <= 1'b0;
      perst_n_o  <= 1'b1;
      train_en_o <= 1'b0;
      busy_o     <= 1'b0;
      ready_o    <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      st_q       <= st_d;
      perst_n_o  <= (st_d != SQ_PERST);
      train_en_o <= (st_d == SQ_LINK);
      ready_o    <= (st_d == SQ_LINK) && (st_q != SQ_LINK);
      err_o      <= (st_d == SQ_FAULT);
      busy_o     <= is_busy_d;
      if (accept_start) begin
        skip_q   <= perst_skip_i;
        slot_o   <= pick_slot(32'(ctrl_idx_i));
        pwr_on_o <= 1'b1;
      end else if (pwr_down_i) begin
        pwr_on_o <= 1'b0;
      end
    end
  end

  assert_busy_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && train_en_o));

  assert_ready_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o);

  assert_train_after_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    train_en_o |-> perst_n_o);

  assert_fault_from_check_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_fail |=> (err_o && !busy_o));

  assert_pwrdn_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_i |=> (!train_en_o && !busy_o && !err_o && perst_n_o && !pwr_on_o));

  assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && !pwr_down_i) |-> !accept_start);

endmodule

// File: rtl/rbs_bringup_seq.sv
module rbs_bringup_seq
  import rbs_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 100,
  parameter int unsigned HOLD_US    = 1000,
  parameter int unsigned PULSE_US   = 5000,
  parameter int unsigned IDX_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             pwr_down_i,
  input  logic             refclk_ok_i,
  input  logic [IDX_W-1:0] ctrl_idx_i,
  input  logic             perst_skip_i,
  output logic [7:0]       phy_pwr_o,
  output logic             apb_rst_n_o,
  output logic             phy_rst_n_o,
  output logic [1:0]       ctrl_rst_n_o,
  output logic             perst_n_o,
  output logic             train_en_o,
  output logic             busy_o,
  output logic             ready_o,
  output logic             err_o
);

  localparam int unsigned HOLD_CYC  = us_to_cyc(HOLD_US, CYC_PER_US);
  localparam int unsigned PULSE_CYC = us_to_cyc(PULSE_US, CYC_PER_US);
  localparam int unsigned MAX_CYC   = (HOLD_CYC > PULSE_CYC) ? HOLD_CYC : PULSE_CYC;
  localparam int unsigned CW        = $clog2(MAX_CYC) + 1;

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_expired;
  logic          hold_all;
  logic          rel_core;
  logic          rel_ctrl;
  logic          slot;
  logic          pwr_on;

  rbs_seq_fsm #(
    .CW        (CW),
    .IDX_W     (IDX_W),
    .HOLD_CYC  (HOLD_CYC),
    .PULSE_CYC (PULSE_CYC)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .pwr_down_i   (pwr_down_i),
    .refclk_ok_i  (refclk_ok_i),
    .ctrl_idx_i   (ctrl_idx_i),
    .perst_skip_i (perst_skip_i),
    .expired_i    (tmr_expired),
    .load_o       (tmr_load),
    .load_val_o   (tmr_val),
    .hold_all_o   (hold_all),
    .rel_core_o   (rel_core),
    .rel_ctrl_o   (rel_ctrl),
    .slot_o       (slot),
    .pwr_on_o     (pwr_on),
    .perst_n_o    (perst_n_o),
    .train_en_o   (train_en_o),
    .busy_o       (busy_o),
    .ready_o      (ready_o),
    .err_o        (err_o)
  );

  rbs_delay_timer #(.CW(CW)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  rbs_reset_bank u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold_all_i   (hold_all),
    .rel_core_i   (rel_core),
    .rel_ctrl_i   (rel_ctrl),
    .slot_i       (slot),
    .apb_rst_n_o  (apb_rst_n_o),
    .phy_rst_n_o  (phy_rst_n_o),
    .ctrl_rst_n_o (ctrl_rst_n_o)
  );

  assign phy_pwr_o = pwr_on ? PHY_WORD_ON : PHY_WORD_OFF;

  assert_err_holds_resets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!apb_rst_n_o && !phy_rst_n_o && ctrl_rst_n_o == 2'b00));

  assert_train_needs_ctrl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    train_en_o |-> (|ctrl_rst_n_o));

  assert_busy_powered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (phy_pwr_o == PHY_WORD_ON));

endmodule

// File: tb/rbs_bringup_seq_test.sv
`timescale 1ns/1ps
module rbs_bringup_seq_test;

  localparam int CPU = 2;
  localparam int HUS = 5;
  localparam int PUS = 20;
  localparam int H   = HUS * CPU;
  localparam int P   = PUS * CPU;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       pwr_down_i = 1'b0;
  logic       refclk_ok_i = 1'b1;
  logic [1:0] ctrl_idx_i = 2'd0;
  logic       perst_skip_i = 1'b0;
  logic [7:0] phy_pwr_o;
  logic       apb_rst_n_o, phy_rst_n_o, perst_n_o, train_en_o, busy_o, ready_o, err_o;
  logic [1:0] ctrl_rst_n_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int mode = 0;   // 0 idle, 1 running or up, 2 clock fault
  int k    = 0;   // edges since accepted start
  int m_slot = 1;
  bit m_skip = 0;

  always #5 clk = ~clk;

  rbs_bringup_seq #(.CYC_PER_US(CPU), .HOLD_US(HUS), .PULSE_US(PUS), .IDX_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pwr_down_i(pwr_down_i),
    .refclk_ok_i(refclk_ok_i), .ctrl_idx_i(ctrl_idx_i), .perst_skip_i(perst_skip_i),
    .phy_pwr_o(phy_pwr_o), .apb_rst_n_o(apb_rst_n_o), .phy_rst_n_o(phy_rst_n_o),
    .ctrl_rst_n_o(ctrl_rst_n_o), .perst_n_o(perst_n_o), .train_en_o(train_en_o),
    .busy_o(busy_o), .ready_o(ready_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mode = 0;
      k = 0;
    end else if (pwr_down_i) begin
      mode = 0;
    end else if (start_i && mode != 1) begin
      mode = 1;
      k = 1;
      m_slot = (ctrl_idx_i == 2'd1) ? 0 : 1;
      m_skip = perst_skip_i;
    end else if (mode == 1) begin
      if (k == 1 && !refclk_ok_i) mode = 2;
      else if (k < 100000) k = k + 1;
    end
  end

  always @(negedge clk) begin
    int e_pwr, e_core, e_ctrl, e_perst, e_train, e_busy, e_ready, e_err, tk;
    if (!done) begin
      e_pwr = 8'h1D; e_core = 0; e_ctrl = 0; e_perst = 1;
      e_train = 0; e_busy = 0; e_ready = 0; e_err = 0;
      if (mode == 2) begin
        e_pwr = 8'h1C; e_err = 1;
      end else if (mode == 1) begin
        tk = m_skip ? 2 + 2*H : 2 + 2*H + P;
        e_pwr   = 8'h1C;
        e_core  = (k >= 2) ? 1 : 0;
        e_ctrl  = (k >= 2 + H) ? ((m_slot == 0) ? 1 : 2) : 0;
        e_perst = (!m_skip && k >= 2 + 2*H && k < 2 + 2*H + P) ? 0 : 1;
        e_train = (k >= tk) ? 1 : 0;
        e_busy  = (k < tk) ? 1 : 0;
        e_ready = (k == tk) ? 1 : 0;
      end
      chk("R2", "phy_pwr", int'(phy_pwr_o), e_pwr);
      chk("R4", "apb_rst_n", int'(apb_rst_n_o), e_core);
      chk("R4", "phy_rst_n", int'(phy_rst_n_o), e_core);
      chk("R5", "ctrl_rst_n", int'(ctrl_rst_n_o), e_ctrl);
      chk("R6", "perst_n", int'(perst_n_o), e_perst);
      chk("R7", "train_en", int'(train_en_o), e_train);
      chk("R8", "busy", int'(busy_o), e_busy);
      chk("R6", "ready", int'(ready_o), e_ready);
      chk("R3", "err", int'(err_o), e_err);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic do_pwrdn();
    @(negedge clk) pwr_down_i = 1'b1;
    @(negedge clk) pwr_down_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    wait_cyc(3);
    // R1: reset values
    chk("R1", "pwr", int'(phy_pwr_o), 8'h1D);
    chk("R1", "resets", int'({apb_rst_n_o, phy_rst_n_o, ctrl_rst_n_o}), 0);
    chk("R1", "perst_n", int'(perst_n_o), 1);
    chk("R1", "flags", int'({train_en_o, busy_o, ready_o, err_o}), 0);
    rst_n = 1'b1;
    wait_cyc(2);

    // index 1, full PERST# pulse
    ctrl_idx_i = 2'd1; perst_skip_i = 1'b0; refclk_ok_i = 1'b1;
    do_start();
    wait_cyc(2 + 2*H + P + 4);
    chk("R10", "up_before", int'(train_en_o), 1);
    do_start();                      // R10: start when up is ignored
    wait_cyc(3);
    chk("R10", "train_kept", int'(train_en_o), 1);
    chk("R10", "busy_kept", int'(busy_o), 0);
    do_pwrdn();
    wait_cyc(1);
    chk("R9", "pwr_off", int'(phy_pwr_o), 8'h1D);
    chk("R9", "resets_low", int'({apb_rst_n_o, phy_rst_n_o, ctrl_rst_n_o}), 0);

    // index 0 with skip; inputs change mid sequence (R11) plus a start while busy (R10)
    ctrl_idx_i = 2'd0; perst_skip_i = 1'b1;
    do_start();
    wait_cyc(3);
    ctrl_idx_i = 2'd1; perst_skip_i = 1'b0;
    do_start();
    wait_cyc(2 + 2*H + 4);
    chk("R11", "slot_latched", int'(ctrl_rst_n_o), 2);
    chk("R11", "skip_latched", int'(train_en_o), 1);
    do_pwrdn();
    wait_cyc(2);

    // clock fault then restart from the fault state, index 2
    ctrl_idx_i = 2'd2; perst_skip_i = 1'b0; refclk_ok_i = 1'b0;
    do_start();
    wait_cyc(6);
    chk("R3", "fault_err", int'(err_o), 1);
    refclk_ok_i = 1'b1;
    do_start();
    wait_cyc(2 + 2*H + P + 3);
    chk("R5", "other_index_bit1", int'(ctrl_rst_n_o), 2);
    // power-down with start in the same cycle
    @(negedge clk) begin pwr_down_i = 1'b1; start_i = 1'b1; end
    @(negedge clk) begin pwr_down_i = 1'b0; start_i = 1'b0; end
    chk("R9", "priority_idle", int'(busy_o), 0);
    wait_cyc(2);

    // power-down between controller release and PERST#
    ctrl_idx_i = 2'd1;
    do_start();
    wait_cyc(H + 4);
    do_pwrdn();
    wait_cyc(3);
    chk("R9", "mid_seq_ctrl", int'(ctrl_rst_n_o), 0);
    chk("R9", "mid_seq_perst", int'(perst_n_o), 1);
    wait_cyc(3);
    finish_run();
  end

endmodule